// File: doc/BRIEF.md
# Dual-Mode 16-bit Down-Counting Timer

This block is a programmable down-counter that sits on a simple register bus. Software writes a start value, and that value is placed into the counter on the same clock edge. On each later active tick the counter drops by one. When a tick arrives while the counter is at zero, an underflow occurs and the interrupt output is latched high. What happens to the count at that point depends on the mode. In free-running mode the counter wraps to all ones and keeps counting. In periodic mode it takes the last written start value again, which gives a repeating interval.

The whole block runs on one clock. Time advances only on single-cycle tick enables. Two such enables come in, one fast and one slow, and a control bit picks which one the counter follows. A second control bit picks the mode. A third control bit lets the count advance; while it is clear, the count is frozen. A write of any value to the acknowledge register drops the interrupt.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the counter, the stored start value and the control register are all zero, and `irq` is low.
- R2: A bus write to address 0 places `bus_wdata` into the counter and into the stored start value on that clock edge. An active tick in the same cycle does not decrement the new value.
- R3: While enabled (control bit 0 = 1), each cycle with the selected tick high lowers a nonzero count by exactly one. The first decrement after a load happens on the first selected tick that comes after the load cycle.
- R4: Control bit 2 picks the tick source: 0 selects `tick_fast` and 1 selects `tick_slow`. The source that is not selected has no effect on the count.
- R5: While control bit 0 is 0, the count keeps its value whatever the ticks do.
- R6: With control bit 1 = 0 (free-running), an active tick at count zero sets the count to 0xFFFF.
- R7: With control bit 1 = 1 (periodic), an active tick at count zero sets the count to the stored start value.
- R8: `irq` goes high on the same clock edge at which the underflow occurs. It then stays high until it is acknowledged.
- R9: A bus write to address 3, with any data, lowers `irq` on that edge. If an underflow happens in the same cycle, `irq` stays high.
- R10: `bus_rdata` is combinational from `bus_addr`. Address 0 returns the stored start value, address 1 the current count, address 2 the control bits in bits [2:0] with zeros above them, and address 3 returns zero. A write to address 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tick_fast | input | 1 | Fast-rate count enable, one cycle wide |
| tick_slow | input | 1 | Slow-rate count enable, one cycle wide |
| irq | output | 1 | Latched underflow interrupt |

## Verification
The assertions take for granted that the tick inputs and the bus strobe are sampled on the core clock and are defined (not X) once reset is released. They also assume a write and a tick may coincide in any combination, and that a new control value takes effect only from the cycle after its write. The stimulus drives every input at the falling edge and holds it through the next rising edge. It also keeps ticks and writes as plain single-cycle levels, so each sampled value is known. The random phase weights loads toward small values so that underflows, wraps and reloads come up often. Directed cases place a load, an acknowledge or a control change in the very cycle of a tick.

// File: rtl/dual_mode_timer_pkg.sv
// Shared definitions for the dual-mode timer: register addresses and
// control field layout. Assumes a 2-bit register address space.
package dual_mode_timer_pkg;

    localparam int ADDR_W = 2;
    localparam int CTRL_W = 3;

    // Register addresses
    typedef enum logic [ADDR_W-1:0] {
        REG_START = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_ACK   = 2'd3
    } reg_addr_e;

    // Control fields; bit 0 enable, bit 1 periodic, bit 2 slow source
    typedef struct packed {
        logic src_slow;
        logic periodic;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
// Register file of the timer. Holds the control bits and the stored start
// value, decodes write strobes into load and acknowledge pulses, and
// builds the combinational read mux. Assumes at most one write per cycle.
module tmr_regs
    import dual_mode_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  count_in,
    output logic [WIDTH-1:0]  bus_rdata,
    output ctrl_t             ctrl_q,
    output logic [WIDTH-1:0]  start_q,
    output logic              load_pulse,
    output logic              ack_pulse
);

    localparam int PAD_W = WIDTH - CTRL_W;

    logic ctrl_we;

    // Decode the write strobe per address
    always_comb begin
        load_pulse = bus_wr && (bus_addr == REG_START);
        ctrl_we    = bus_wr && (bus_addr == REG_CTRL);
        ack_pulse  = bus_wr && (bus_addr == REG_ACK);
    end

    // Control register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    // Stored start value, used later for periodic reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (load_pulse) begin
            start_q <= bus_wdata;
        end
    end

    // Read mux
    always_comb begin
        case (bus_addr)
            REG_START: bus_rdata = start_q;
            REG_COUNT: bus_rdata = count_in;
            REG_CTRL:  bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_tick_sel.sv
// Picks one of several single-cycle tick enables by index. Assumes all
// ticks are synchronous to the core clock. Purely combinational.
module tmr_tick_sel #(
    parameter int N_SRC = 2,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_out
);

    generate
        if (N_SRC == 1) begin : g_single
            logic unused_sel;
            // Only one source: pass it straight through
            always_comb begin
                unused_sel = |sel;
                tick_out   = ticks[0];
            end
        end else begin : g_multi
            // Index the selected tick
            always_comb begin
                tick_out = 1'b0;
                for (int i = 0; i < N_SRC; i++) begin
                    if (sel == SEL_W'(i)) tick_out = ticks[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tmr_core.sv
// Down-counter with load, wrap or reload on underflow, and a latched
// interrupt. A load takes priority over counting in the same cycle. An
// underflow takes priority over an acknowledge in the same cycle.
module tmr_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] start_val,
    input  logic             enable,
    input  logic             periodic,
    input  logic             tick,
    input  logic             ack,
    output logic [WIDTH-1:0] count_q,
    output logic             irq_q
);

    localparam logic [WIDTH-1:0] WRAP_VAL = {WIDTH{1'b1}};

    logic             step;
    logic             at_zero;
    logic             underflow;
    logic [WIDTH-1:0] count_d;

    // Decide whether this cycle counts and whether it underflows
    always_comb begin
        step      = enable && tick && !load;
        at_zero   = (count_q == '0);
        underflow = step && at_zero;
    end

    // Next count value
    always_comb begin
        if (load) begin
            count_d = load_val;
        end else if (step) begin
            if (at_zero) count_d = periodic ? start_val : WRAP_VAL;
            else         count_d = count_q - 1'b1;
        end else begin
            count_d = count_q;
        end
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // Interrupt latch: set on underflow, clear on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (underflow) irq_q <= 1'b1;
        else if (ack)       irq_q <= 1'b0;
    end

endmodule

// File: rtl/dual_mode_timer.sv
// Top of the dual-mode timer. Connects the register file, the tick source
// selector and the counter core. Assumes a single clock domain with the
// tick inputs synchronous to it.
module dual_mode_timer
    import dual_mode_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              irq
);

    ctrl_t            ctrl_q;
    logic [WIDTH-1:0] start_q;
    logic [WIDTH-1:0] count_q;
    logic             load_pulse;
    logic             ack_pulse;
    logic             tick_act;

    tmr_regs #(.WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count_in   (count_q),
        .bus_rdata  (bus_rdata),
        .ctrl_q     (ctrl_q),
        .start_q    (start_q),
        .load_pulse (load_pulse),
        .ack_pulse  (ack_pulse)
    );

    tmr_tick_sel #(.N_SRC(2)) u_tick_sel (
        .ticks    ({tick_slow, tick_fast}),
        .sel      (ctrl_q.src_slow),
        .tick_out (tick_act)
    );

    tmr_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_pulse),
        .load_val  (bus_wdata),
        .start_val (start_q),
        .enable    (ctrl_q.enable),
        .periodic  (ctrl_q.periodic),
        .tick      (tick_act),
        .ack       (ack_pulse),
        .count_q   (count_q),
        .irq_q     (irq)
    );

endmodule

// File: rtl/dual_mode_timer_chk.sv
// Property checker for the dual-mode timer, bound into the top module.
// Decodes the bus on its own and relates it to the count and interrupt.
module dual_mode_timer_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] count_q,
    input logic [WIDTH-1:0] start_q,
    input logic [2:0]       ctrl_bits,
    input logic             tick_fast,
    input logic             tick_slow,
    input logic             irq
);

    logic is_load, is_ack, tk, adv, uflow;

    // Independent decode of the stimulus seen by the block
    always_comb begin
        is_load = bus_wr && (bus_addr == 2'd0);
        is_ack  = bus_wr && (bus_addr == 2'd3);
        tk      = ctrl_bits[2] ? tick_slow : tick_fast;
        adv     = ctrl_bits[0] && tk && !is_load;
        uflow   = adv && (count_q == '0);
    end

    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> (count_q == $past(bus_wdata)) && (start_q == $past(bus_wdata))); // R2

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && count_q != '0) |=> count_q == $past(count_q) - 1'b1); // R3

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[0] && !is_load) |=> $stable(count_q)); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tk && !is_load) |=> $stable(count_q)); // R4

    AST_WRAP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !ctrl_bits[1]) |=> count_q == {WIDTH{1'b1}}); // R6

    AST_RELOAD_PER: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && ctrl_bits[1]) |=> count_q == $past(start_q)); // R7

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> irq); // R8

    AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !is_ack) |=> irq); // R8

    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ack && !uflow) |=> !irq); // R9

    AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !uflow) |=> !irq); // R8

endmodule

bind dual_mode_timer dual_mode_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count_q   (count_q),
    .start_q   (start_q),
    .ctrl_bits (ctrl_q),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .irq       (irq)
);

// File: tb/dual_mode_timer_bench.sv
`timescale 1ns/1ps
module dual_mode_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;

    // Reference state, built from the requirements
    logic [15:0] m_cnt = '0;
    logic [15:0] m_start = '0;
    logic [2:0]  m_ctrl = '0;
    logic        m_irq = 1'b0;

    dual_mode_timer u_dual_mode_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [15:0] next_count(logic [15:0] c, logic [15:0] s,
                                               logic [2:0] ct, logic ld,
                                               logic [15:0] d, logic tk);
        if (ld) return d;
        if (!(ct[0] && tk)) return c;
        if (c == 16'd0) return ct[1] ? s : 16'hFFFF;
        return c - 16'd1;
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
    endtask

    // One clock cycle of stimulus; reference advanced from the same inputs
    task automatic step(logic we, logic [1:0] a, logic [15:0] d, logic tf, logic ts);
        logic tk, ld, uf;
        logic [15:0] nc;
        @(negedge clk);
        bus_wr = we; bus_addr = a; bus_wdata = d; tick_fast = tf; tick_slow = ts;
        tk = m_ctrl[2] ? ts : tf;
        ld = we && a == 2'd0;
        uf = !ld && m_ctrl[0] && tk && m_cnt == 16'd0;
        nc = next_count(m_cnt, m_start, m_ctrl, ld, d, tk);
        @(posedge clk);
        #1;
        m_cnt = nc;
        if (ld) m_start = d;
        if (we && a == 2'd2) m_ctrl = d[2:0];
        if (uf) m_irq = 1'b1;
        else if (we && a == 2'd3) m_irq = 1'b0;
        bus_wr = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
    endtask

    task automatic chk_cnt(string tag, logic [15:0] exp);
        logic [15:0] v;
        rd(2'd1, v);
        check(tag, v, exp);
    endtask

    task automatic chk_irq(string tag, logic exp);
        #0.2;
        check(tag, {15'd0, irq}, {15'd0, exp});
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd24680));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.2;

        // R1: reset state
        rd(2'd0, v); check("R1 start", v, 16'd0);
        rd(2'd1, v); check("R1 count", v, 16'd0);
        rd(2'd2, v); check("R1 ctrl", v, 16'd0);
        chk_irq("R1 irq", 1'b0);

        // R2: load with a coincident tick, enabled, fast source
        step(1, 2'd2, 16'h0001, 0, 0);
        step(1, 2'd0, 16'd5, 1, 0);
        chk_cnt("R2 load ignores same-cycle tick", 16'd5);
        rd(2'd0, v); check("R2 start stored", v, 16'd5);

        // R3: decrement per selected tick only
        step(0, 2'd0, 0, 1, 0); chk_cnt("R3 first tick", 16'd4);
        step(0, 2'd0, 0, 0, 0); chk_cnt("R3 no tick", 16'd4);
        step(0, 2'd0, 0, 1, 0); chk_cnt("R3 second tick", 16'd3);

        // R4: unselected slow tick has no effect
        step(0, 2'd0, 0, 0, 1); chk_cnt("R4 slow ignored", 16'd3);

        // R5: disable (old enable still counts in its write cycle)
        step(1, 2'd2, 16'h0000, 1, 0); chk_cnt("R5 write cycle", 16'd2);
        step(0, 2'd0, 0, 1, 1); chk_cnt("R5 hold", 16'd2);

        // R4/R6/R8: slow source, free mode, wrap and interrupt
        step(1, 2'd2, 16'h0005, 0, 0);
        step(0, 2'd0, 0, 0, 1); chk_cnt("R4 slow tick", 16'd1);
        step(0, 2'd0, 0, 0, 1); chk_cnt("R3 to zero", 16'd0);
        chk_irq("R8 no irq at zero", 1'b0);
        step(0, 2'd0, 0, 0, 1); chk_cnt("R6 wrap", 16'hFFFF);
        chk_irq("R8 irq on underflow", 1'b1);
        step(0, 2'd0, 0, 1, 0); chk_cnt("R4 fast ignored", 16'hFFFF);
        chk_irq("R8 irq latched", 1'b1);

        // R9: acknowledge
        step(1, 2'd3, 16'hABCD, 0, 0); chk_irq("R9 ack clears", 1'b0);

        // R7: periodic reload
        step(1, 2'd2, 16'h0003, 0, 0);
        step(1, 2'd0, 16'd2, 0, 0);
        step(0, 2'd0, 0, 1, 0);
        step(0, 2'd0, 0, 1, 0); chk_cnt("R7 at zero", 16'd0);
        step(0, 2'd0, 0, 1, 0); chk_cnt("R7 reload", 16'd2);
        chk_irq("R8 periodic irq", 1'b1);

        // R9: underflow wins over a same-cycle acknowledge
        step(0, 2'd0, 0, 1, 0);
        step(0, 2'd0, 0, 1, 0);
        step(1, 2'd3, 16'd0, 1, 0); chk_irq("R9 underflow beats ack", 1'b1);
        chk_cnt("R7 reload again", 16'd2);
        step(1, 2'd3, 16'd0, 0, 0); chk_irq("R9 ack alone", 1'b0);

        // R10: readback map, count register is not writable
        step(1, 2'd1, 16'h1234, 0, 0); chk_cnt("R10 count write ignored", 16'd2);
        rd(2'd3, v); check("R10 ack reads zero", v, 16'd0);
        rd(2'd2, v); check("R10 ctrl readback", v, 16'h0003);
        rd(2'd0, v); check("R10 start readback", v, 16'd2);

        // Random phase against the reference
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [1:0] a;
            logic [15:0] d;
            we = ($urandom % 8) == 0;
            a  = 2'($urandom % 4);
            d  = (($urandom % 4) != 0) ? 16'($urandom % 6) : 16'($urandom);
            if (a == 2'd2 && ($urandom % 4) != 0) d[0] = 1'b1;
            step(we, a, d, 1'($urandom % 2), 1'($urandom % 2));
            chk_cnt("R3/R6/R7 random count", m_cnt);
            chk_irq("R8/R9 random irq", m_irq);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule